// File: doc/BRIEF.md
# Dual-Host Scratchpad Store With Peer Access

This block holds the scratchpad words that two hosts on either side of a bridge use to swap control and status information. Each host owns one array of scratchpad words. A host reaches its own array through its first aperture. In that aperture the configuration words come first, and the scratchpad begins at a word offset that can be programmed. The other host reaches the same array through its second aperture, where the scratchpad begins at word zero. The block therefore holds two independent arrays, and each array can be accessed from two sides.

The block decodes every request against both apertures of both ports. It limits scratchpad indices to the advertised word count. An access that falls below the scratchpad offset in the first aperture is forwarded to an external configuration register port, and that port's read data is returned through the same response path. Every request is answered after exactly one cycle. When two sides hit one array in the same cycle, both requests are served, and the self side has priority if both write the same word.

Top module: `spad_bridge`

## Requirements
- R1: While reset is held, and on the first cycle after it, `ack_o` is 0 and `rdata_o` is 0. All scratchpad words read as zero after reset.
- R2: A request on port p with `ap_i`=0 and `addr_i` >= `spad_off_i[p]` accesses word `addr_i - spad_off_i[p]` of array p. For a read, the data appears on `rdata_o[p]` together with `ack_o[p]` one cycle after the request.
- R3: A request on port p with `ap_i`=1 accesses word `addr_i` of the array owned by the other port. Words written this way can be read back through the owner's self path, and the reverse also holds.
- R4: The two arrays are independent. A write to one array never changes any word of the other array.
- R5: A request with `ap_i`=0 and `addr_i` < `spad_off_i[p]` raises `cfg_req_o[p]` in the same cycle, with the address, write flag and write data forwarded. It changes no scratchpad word. A read returns the `cfg_rdata_i[p]` value of the request cycle one cycle later.
- R6: A scratchpad index at or above min(owner's `spad_cnt_i`, DEPTH) reads as 0, and a write to such an index is ignored. The bound for a peer access uses the owning port's count.
- R7: When the self side and the peer side write the same word of one array in the same cycle, the self-side data is stored and both requests are acknowledged.
- R8: When one side reads a word that the other side writes in the same cycle, the read returns the old value. Two writes to different words of one array in the same cycle are both stored.
- R9: Every request is acknowledged exactly one cycle later, and `ack_o` is low when no request was made in the previous cycle. A write returns `rdata_o`=0.
- R10: Changing `spad_off_i[p]` moves the boundary between the configuration words and the scratchpad immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 2 | Request strobe per port |
| we_i | input | 2 | Write when 1, read when 0, per port |
| ap_i | input | 2 | Aperture select per port: 0 config+self, 1 peer |
| addr_i | input | 2x ADDR_W | Word address inside the aperture, per port |
| wdata_i | input | 2x DATA_W | Write data per port |
| spad_off_i | input | 2x ADDR_W | Scratchpad start word in the first aperture, per port |
| spad_cnt_i | input | 2x ADDR_W | Advertised scratchpad word count, per port |
| ack_o | output | 2 | Response strobe, one cycle after request |
| rdata_o | output | 2x DATA_W | Read data, valid with ack_o |
| cfg_req_o | output | 2 | Forwarded configuration access strobe |
| cfg_we_o | output | 2 | Forwarded write flag |
| cfg_addr_o | output | 2x ADDR_W | Forwarded word address |
| cfg_wdata_o | output | 2x DATA_W | Forwarded write data |
| cfg_rdata_i | input | 2x DATA_W | Read data from the configuration register block |

## Verification
The bench targets the index bounds. A design that compares against DEPTH instead of the advertised count, or that uses the requester's own count for a peer access, would return stored data where zero is expected. It checks the self-versus-peer collision on one word; a design with reversed priority would leave the peer's data in the word. It also checks a read that meets a write in the same cycle, where a design that forwards the write data would return the new value instead of the old one. Offset shifts and the configuration passthrough are exercised so that an off-by-one at the aperture boundary sends a word to the wrong destination.

// File: rtl/spad_bridge_pkg.sv
package spad_bridge_pkg;

    // Destination of one decoded request
    typedef enum logic [2:0] {
        RT_NONE = 3'd0,
        RT_CFG  = 3'd1,
        RT_SELF = 3'd2,
        RT_PEER = 3'd3,
        RT_VOID = 3'd4
    } route_e;

    localparam int NPORT = 2;

endpackage

// File: rtl/spad_decode.sv
module spad_decode
    import spad_bridge_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              req_i,
    input  logic              ap_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] off_i,
    input  logic [ADDR_W-1:0] self_cnt_i,
    input  logic [ADDR_W-1:0] peer_cnt_i,
    output route_e            route_o,
    output logic [IDX_W-1:0]  idx_o
);

    localparam logic [ADDR_W-1:0] DEPTH_A = ADDR_W'(DEPTH);

    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] self_lim;
    logic [ADDR_W-1:0] peer_lim;

    always_comb begin
        self_lim = (self_cnt_i > DEPTH_A) ? DEPTH_A : self_cnt_i;
        peer_lim = (peer_cnt_i > DEPTH_A) ? DEPTH_A : peer_cnt_i;
        rel      = addr_i - off_i;
        route_o  = RT_NONE;
        idx_o    = '0;
        if (req_i) begin
            if (ap_i) begin
                // peer aperture: scratchpad starts at word zero
                idx_o   = addr_i[IDX_W-1:0];
                route_o = (addr_i < peer_lim) ? RT_PEER : RT_VOID;
            end else if (addr_i < off_i) begin
                route_o = RT_CFG;
            end else begin
                idx_o   = rel[IDX_W-1:0];
                route_o = (rel < self_lim) ? RT_SELF : RT_VOID;
            end
        end
    end

endmodule

// File: rtl/spad_bank.sv
module spad_bank #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              s_we_i,
    input  logic [IDX_W-1:0]  s_idx_i,
    input  logic [DATA_W-1:0] s_wd_i,
    input  logic              p_we_i,
    input  logic [IDX_W-1:0]  p_idx_i,
    input  logic [DATA_W-1:0] p_wd_i,
    output logic [DATA_W-1:0] s_rd_o,
    output logic [DATA_W-1:0] p_rd_o
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // peer write first, so a self write to the same word overrides it
        if (p_we_i) st_d.mem[p_idx_i] = p_wd_i;
        if (s_we_i) st_d.mem[s_idx_i] = s_wd_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // reads see the stored value, never the same-cycle write
    assign s_rd_o = st_q.mem[s_idx_i];
    assign p_rd_o = st_q.mem[p_idx_i];

endmodule

// File: rtl/spad_bridge.sv
module spad_bridge
    import spad_bridge_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic [1:0]                    req_i,
    input  logic [1:0]                    we_i,
    input  logic [1:0]                    ap_i,
    input  logic [1:0][ADDR_W-1:0]        addr_i,
    input  logic [1:0][DATA_W-1:0]        wdata_i,
    input  logic [1:0][ADDR_W-1:0]        spad_off_i,
    input  logic [1:0][ADDR_W-1:0]        spad_cnt_i,
    output logic [1:0]                    ack_o,
    output logic [1:0][DATA_W-1:0]        rdata_o,
    output logic [1:0]                    cfg_req_o,
    output logic [1:0]                    cfg_we_o,
    output logic [1:0][ADDR_W-1:0]        cfg_addr_o,
    output logic [1:0][DATA_W-1:0]        cfg_wdata_o,
    input  logic [1:0][DATA_W-1:0]        cfg_rdata_i
);

    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        logic [NPORT-1:0]             ack;
        logic [NPORT-1:0][DATA_W-1:0] rdata;
    } rsp_t;

    route_e                      route [NPORT];
    logic [NPORT-1:0][IDX_W-1:0] idx;
    logic [NPORT-1:0][DATA_W-1:0] self_rd;
    logic [NPORT-1:0][DATA_W-1:0] peer_rd;

    rsp_t rsp_d, rsp_q;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        localparam int Q = NPORT - 1 - p;

        spad_decode #(
            .ADDR_W (ADDR_W),
            .DEPTH  (DEPTH)
        ) u_dec (
            .req_i      (req_i[p]),
            .ap_i       (ap_i[p]),
            .addr_i     (addr_i[p]),
            .off_i      (spad_off_i[p]),
            .self_cnt_i (spad_cnt_i[p]),
            .peer_cnt_i (spad_cnt_i[Q]),
            .route_o    (route[p]),
            .idx_o      (idx[p])
        );

        // array p: self side is port p, peer side is the opposite port
        spad_bank #(
            .DATA_W (DATA_W),
            .DEPTH  (DEPTH)
        ) u_bank (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .s_we_i  (route[p] == RT_SELF && we_i[p]),
            .s_idx_i (idx[p]),
            .s_wd_i  (wdata_i[p]),
            .p_we_i  (route[Q] == RT_PEER && we_i[Q]),
            .p_idx_i (idx[Q]),
            .p_wd_i  (wdata_i[Q]),
            .s_rd_o  (self_rd[p]),
            .p_rd_o  (peer_rd[p])
        );

        assign cfg_req_o[p]   = (route[p] == RT_CFG);
        assign cfg_we_o[p]    = (route[p] == RT_CFG) && we_i[p];
        assign cfg_addr_o[p]  = addr_i[p];
        assign cfg_wdata_o[p] = wdata_i[p];
    end

    always_comb begin
        rsp_d = '0;
        for (int p = 0; p < NPORT; p++) begin
            rsp_d.ack[p] = req_i[p];
            if (req_i[p] && !we_i[p]) begin
                unique case (route[p])
                    RT_CFG:  rsp_d.rdata[p] = cfg_rdata_i[p];
                    RT_SELF: rsp_d.rdata[p] = self_rd[p];
                    RT_PEER: rsp_d.rdata[p] = peer_rd[NPORT-1-p];
                    default: rsp_d.rdata[p] = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) rsp_q <= '0;
        else         rsp_q <= rsp_d;
    end

    assign ack_o   = rsp_q.ack;
    assign rdata_o = rsp_q.rdata;

endmodule

// File: rtl/spad_bridge_chk.sv
module spad_bridge_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic [1:0]             req_i,
    input logic [1:0]             we_i,
    input logic [1:0]             ap_i,
    input logic [1:0][ADDR_W-1:0] addr_i,
    input logic [1:0][ADDR_W-1:0] spad_off_i,
    input logic [1:0][ADDR_W-1:0] spad_cnt_i,
    input logic [1:0]             ack_o,
    input logic [1:0][DATA_W-1:0] rdata_o,
    input logic [1:0]             cfg_req_o,
    input logic [1:0][DATA_W-1:0] cfg_rdata_i
);

    localparam logic [ADDR_W-1:0] DEPTH_A = ADDR_W'(DEPTH);

    // reset leaves responses quiet
    assert_reset_quiet_R1: assert property (@(posedge clk_i)
        !rst_ni |=> (ack_o == '0 && rdata_o == '0));

    for (genvar p = 0; p < 2; p++) begin : g_chk
        localparam int Q = 1 - p;
        logic [ADDR_W-1:0] peer_lim;
        assign peer_lim = (spad_cnt_i[Q] > DEPTH_A) ? DEPTH_A : spad_cnt_i[Q];

        assert_ack_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            req_i[p] |=> ack_o[p]);

        assert_no_spurious_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !req_i[p] |=> !ack_o[p]);

        assert_write_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (req_i[p] && we_i[p]) |=> rdata_o[p] == '0);

        assert_cfg_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            cfg_req_o[p] |-> (req_i[p] && !ap_i[p] && addr_i[p] < spad_off_i[p]));

        assert_cfg_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (req_i[p] && !we_i[p] && !ap_i[p] && addr_i[p] < spad_off_i[p])
            |=> rdata_o[p] == $past(cfg_rdata_i[p]));

        assert_peer_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (req_i[p] && !we_i[p] && ap_i[p] && addr_i[p] >= peer_lim)
            |=> rdata_o[p] == '0);
    end

endmodule

bind spad_bridge spad_bridge_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .ap_i        (ap_i),
    .addr_i      (addr_i),
    .spad_off_i  (spad_off_i),
    .spad_cnt_i  (spad_cnt_i),
    .ack_o       (ack_o),
    .rdata_o     (rdata_o),
    .cfg_req_o   (cfg_req_o),
    .cfg_rdata_i (cfg_rdata_i)
);

// File: tb/spad_bridge_bench.sv
module spad_bridge_bench;

    localparam int AW = 8;
    localparam int DW = 32;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [1:0]          req = '0, we = '0, ap = '0;
    logic [1:0][AW-1:0]  addr = '0;
    logic [1:0][DW-1:0]  wdata = '0;
    logic [1:0][AW-1:0]  off, cnt;
    logic [1:0]          ack, cfg_req, cfg_we;
    logic [1:0][DW-1:0]  rdata, cfg_wdata, cfg_rdata;
    logic [1:0][AW-1:0]  cfg_addr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    // config block model: data tagged by port and address
    for (genvar p = 0; p < 2; p++) begin : g_cfg
        assign cfg_rdata[p] = 32'hCF00_0000 | (DW'(p) << 16) | DW'(cfg_addr[p]);
    end

    spad_bridge #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(8)) u_spad_bridge (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .ap_i(ap),
        .addr_i(addr), .wdata_i(wdata), .spad_off_i(off), .spad_cnt_i(cnt),
        .ack_o(ack), .rdata_o(rdata), .cfg_req_o(cfg_req), .cfg_we_o(cfg_we),
        .cfg_addr_o(cfg_addr), .cfg_wdata_o(cfg_wdata), .cfg_rdata_i(cfg_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic          p;
        logic          we;
        logic          ap;
        logic [AW-1:0] addr;
        logic [DW-1:0] wd;
        logic [DW-1:0] exp;
        logic [3:0]    rq;
    } vec_t;

    // offsets: port0=4, port1=6; counts: port0=8, port1=5
    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 1'b0, 8'd4,   32'h1111_1111, 32'h0,          4'd2},  // R2 write arr0[0]
        '{1'b0, 1'b0, 1'b0, 8'd4,   32'h0,         32'h1111_1111,  4'd2},  // R2 read back
        '{1'b1, 1'b0, 1'b1, 8'd0,   32'h0,         32'h1111_1111,  4'd3},  // R3 peer read arr0[0]
        '{1'b1, 1'b1, 1'b1, 8'd7,   32'h2222_2222, 32'h0,          4'd3},  // R3 peer write arr0[7]
        '{1'b0, 1'b0, 1'b0, 8'd11,  32'h0,         32'h2222_2222,  4'd3},  // R3 owner sees it
        '{1'b1, 1'b1, 1'b0, 8'd6,   32'h3333_3333, 32'h0,          4'd4},  // R4 write arr1[0]
        '{1'b0, 1'b0, 1'b0, 8'd4,   32'h0,         32'h1111_1111,  4'd4},  // R4 arr0 untouched
        '{1'b0, 1'b0, 1'b1, 8'd0,   32'h0,         32'h3333_3333,  4'd4},  // R4 arr1 via peer
        '{1'b1, 1'b1, 1'b0, 8'd11,  32'h4444_4444, 32'h0,          4'd6},  // R6 arr1[5] beyond count
        '{1'b0, 1'b0, 1'b1, 8'd5,   32'h0,         32'h0,          4'd6},  // R6 peer uses owner count
        '{1'b0, 1'b1, 1'b1, 8'd4,   32'h5555_5555, 32'h0,          4'd6},  // R6 last legal word
        '{1'b1, 1'b0, 1'b0, 8'd10,  32'h0,         32'h5555_5555,  4'd6},  // R6 read it back
        '{1'b0, 1'b0, 1'b0, 8'd2,   32'h0,         32'hCF00_0002,  4'd5},  // R5 cfg read port0
        '{1'b1, 1'b0, 1'b0, 8'd5,   32'h0,         32'hCF01_0005,  4'd5},  // R5 cfg read port1
        '{1'b0, 1'b1, 1'b0, 8'd1,   32'h6666_6666, 32'h0,          4'd9},  // R9 write gives zero
        '{1'b0, 1'b0, 1'b0, 8'd200, 32'h0,         32'h0,          4'd6}   // R6 far out of range
    };

    // drive one cycle of requests on both ports, then sample the response
    task automatic cyc(input logic [1:0] r, input logic [1:0] w, input logic [1:0] a,
                       input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                       input logic [DW-1:0] d0, input logic [DW-1:0] d1);
        req = r; we = w; ap = a;
        addr[0] = a0; addr[1] = a1; wdata[0] = d0; wdata[1] = d1;
        @(posedge clk);
        @(negedge clk);
        req = '0; we = '0;
    endtask

    task automatic rd(input bit p, input bit a, input logic [AW-1:0] ad,
                      input logic [DW-1:0] exp, input string tag);
        if (p) cyc(2'b10, 2'b00, {a, 1'b0}, '0, ad, '0, '0);
        else   cyc(2'b01, 2'b00, {1'b0, a}, ad, '0, '0, '0);
        chk(ack[p] && rdata[p] == exp, tag, rdata[p], exp);
    endtask

    initial begin
        off[0] = 8'd4; off[1] = 8'd6;
        cnt[0] = 8'd8; cnt[1] = 8'd5;
        repeat (3) @(negedge clk);
        chk(ack == '0 && rdata == '0, "R1 during reset", DW'(ack), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ack == '0, "R1 after reset ack", DW'(ack), '0);
        rd(1'b0, 1'b0, 8'd5, '0, "R1 spad cleared");
        rd(1'b1, 1'b1, 8'd3, '0, "R1 peer cleared");

        for (int i = 0; i < NV; i++) begin
            vec_t v = VECS[i];
            if (v.p) cyc(2'b10, {v.we, 1'b0}, {v.ap, 1'b0}, '0, v.addr, '0, v.wd);
            else     cyc(2'b01, {1'b0, v.we}, {1'b0, v.ap}, v.addr, '0, v.wd, '0);
            total++;
            if (!(ack[v.p] && rdata[v.p] == v.exp)) begin
                bad++;
                $display("FAIL R%0d vector %0d actual=%h ack=%b expected=%h",
                         v.rq, i, rdata[v.p], ack[v.p], v.exp);
            end
        end

        // R9: idle cycle, no ack
        @(negedge clk);
        chk(ack == '0, "R9 idle ack", DW'(ack), '0);

        // R5: passthrough fields visible in the request cycle; scratchpad untouched
        req = 2'b01; we = 2'b01; ap = 2'b00; addr[0] = 8'd3; wdata[0] = 32'hABCD_0123;
        #1;
        chk(cfg_req == 2'b01 && cfg_we[0] && cfg_addr[0] == 8'd3 &&
            cfg_wdata[0] == 32'hABCD_0123, "R5 forward", DW'({cfg_req, cfg_we}), 32'h5);
        @(posedge clk); @(negedge clk); req = '0; we = '0;
        rd(1'b0, 1'b0, 8'd4, 32'h1111_1111, "R5 cfg write kept out of spad");

        // R7: same word, self wins, both acked
        cyc(2'b11, 2'b11, 2'b10, 8'd6, 8'd2, 32'hAAAA_AAAA, 32'hBBBB_BBBB);
        chk(ack == 2'b11, "R7 both acked", DW'(ack), 32'h3);
        rd(1'b1, 1'b1, 8'd2, 32'hAAAA_AAAA, "R7 self data stored");

        // R8: read meets write -> old value
        cyc(2'b11, 2'b01, 2'b10, 8'd7, 8'd3, 32'hCCCC_CCCC, '0);
        chk(rdata[1] == '0, "R8 old value on collision", rdata[1], '0);
        rd(1'b1, 1'b1, 8'd3, 32'hCCCC_CCCC, "R8 write landed");
        // R8: two different words both stored
        cyc(2'b11, 2'b11, 2'b10, 8'd8, 8'd5, 32'hDDDD_DDDD, 32'hEEEE_EEEE);
        rd(1'b0, 1'b0, 8'd8, 32'hDDDD_DDDD, "R8 self word");
        rd(1'b0, 1'b0, 8'd9, 32'hEEEE_EEEE, "R8 peer word");

        // R10: move port0 boundary to 2
        off[0] = 8'd2;
        rd(1'b0, 1'b0, 8'd2, 32'h1111_1111, "R10 new boundary maps word0");
        rd(1'b0, 1'b0, 8'd1, 32'hCF00_0001, "R10 below boundary still cfg");

        // R6: count above DEPTH clamps to DEPTH
        cnt[1] = 8'd20;
        rd(1'b1, 1'b0, 8'd14, '0, "R6 clamp to depth");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule